// File: doc/BRIEF.md
# Serial Receive Status Flag Controller

This block sits behind the bit-level receiver of a serial port. It holds the most recent received byte, and it keeps three sticky status flags: receive-full, overrun and idle. The receiver core reports each finished character with a one-cycle pulse that carries the byte. It reports an idle line with another one-cycle pulse. Software reads the status register and then the data register, and the bus signals each of these reads with its own one-cycle strobe.

Flags never clear on a single access. A status read records which flags were set at that moment. The next data read then clears exactly those flags and no others. If a character arrives while the held byte is still unread, that character is lost, the held byte is kept, and the overrun flag is raised. The overrun flag can raise an error interrupt. The idle flag can set only after a valid character has been loaded since the receiver was enabled, and again after each time the idle flag is cleared. This stops an idle line from being reported before any traffic has been seen.

Top module: `rx_status_ctrl`

## Requirements
- R1: While reset is active, and after it is released, the flags receive-full, overrun and idle, the interrupt request and the held byte are all 0.
- R2: A character pulse with the receiver enabled and receive-full clear loads the byte into the held register and sets receive-full on the next clock.
- R3: Receive-full clears only on a data read that follows a status read made while receive-full was set. A data read with no such status read before it leaves receive-full set.
- R4: A character pulse while receive-full is set (and not being cleared in that cycle) sets overrun, discards the new byte and leaves the held byte unchanged.
- R5: Overrun clears only on a data read that follows a status read made while overrun was set. If overrun was clear when status was read, the next data read leaves overrun set, even if overrun became set between the two reads.
- R6: The error interrupt output is high exactly when overrun is set and the overrun interrupt enable is high.
- R7: After the receiver is enabled, an idle pulse sets the idle flag only once a character has loaded the held register. An idle pulse before that has no effect.
- R8: After the idle flag has been cleared by the status-then-data read sequence, idle pulses are ignored until another character loads the held register.
- R9: When a character pulse arrives in the same cycle as a data read that clears receive-full, the read takes effect first. The new byte loads, receive-full stays set and overrun does not set.
- R10: While the receiver is disabled, character pulses have no effect. Dropping the enable also discards the idle arming, so after the receiver is enabled again, a new character is needed before idle can set.
- R11: A data read uses up the arming made by the previous status read. A second data read with no new status read clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rx_en | input | 1 | Receiver enable |
| char_done | input | 1 | One-cycle pulse: a character has completed |
| char_data | input | DATA_W | Byte carried with char_done |
| idle_det | input | 1 | One-cycle pulse: idle line detected |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| ovr_ie | input | 1 | Overrun interrupt enable |
| full_o | output | 1 | Receive-full flag |
| ovr_o | output | 1 | Overrun flag |
| idle_o | output | 1 | Idle flag |
| data_o | output | DATA_W | Held received byte |
| err_irq_o | output | 1 | Error interrupt request |

## Verification
The assertions assume that a status read strobe and a data read strobe never arrive in the same cycle, as would happen on a bus that performs one access at a time. One of the assertions checks this. They also assume that the strobes are single-cycle pulses, sampled synchronously. The directed stimulus issues every read as a separate one-cycle pulse on its own clock. Characters and idle pulses are the only inputs that are ever made to coincide with a read, and only in the scenario that tests character arrival during a clearing read.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  // Sticky receive status flags, also used for the per-flag clear arming.
  typedef struct packed {
    logic idle;
    logic ovr;
    logic full;
  } rxs_flags_t;

endpackage

// File: rtl/rxs_rst_sync.sv
module rxs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);

  logic [STAGES-1:0] sync_q;

  // Reset asserts at once and is released only after STAGES clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_int_n = sync_q[STAGES-1];

endmodule

// File: rtl/rxs_clr_arm.sv
module rxs_clr_arm
  import rxs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stat_rd,
  input  logic       data_rd,
  input  rxs_flags_t flags_i,
  output rxs_flags_t clr_o
);

  rxs_flags_t arm_q;
  rxs_flags_t arm_d;

  // A data read consumes the arming. A status read records the flags that are set now.
  always_comb begin
    arm_d = arm_q;
    if (data_rd) arm_d = '0;
    if (stat_rd) arm_d = flags_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= '0;
    end else begin
      arm_q <= arm_d;
    end
  end

  assign clr_o = data_rd ? arm_q : '0;

  // R11: once a data read has consumed it, no arming is left
  p_arm_consumed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !stat_rd) |=> (arm_q == '0));

  // R5: a flag is armed only if it was set when the status read happened
  p_arm_only_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !flags_i.ovr) |=> !arm_q.ovr);

endmodule

// File: rtl/rxs_hold.sv
module rxs_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              char_done,
  input  logic [DATA_W-1:0] char_data,
  input  logic              clr_full,
  input  logic              clr_ovr,
  output logic              full_o,
  output logic              ovr_o,
  output logic              load_o,
  output logic [DATA_W-1:0] data_o
);

  logic              full_q, full_d;
  logic              ovr_q, ovr_d;
  logic [DATA_W-1:0] data_q;
  logic              char_ok;
  logic              full_eff;
  logic              load;
  logic              ovr_set;

  // The clearing read acts first. A character then either loads or overruns.
  always_comb begin
    char_ok  = char_done & rx_en;
    full_eff = full_q & ~clr_full;
    load     = char_ok & ~full_eff;
    ovr_set  = char_ok & full_eff;
    full_d   = full_eff | load;
    ovr_d    = (ovr_q & ~clr_ovr) | ovr_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      full_q <= full_d;
      ovr_q  <= ovr_d;
    end
  end

  // The held byte has its own clock enable: it changes only on a load.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (load) begin
      data_q <= char_data;
    end
  end

  assign full_o = full_q;
  assign ovr_o  = ovr_q;
  assign load_o = load;
  assign data_o = data_q;

  // R4: a character that arrives while the byte is still unread leaves the byte alone
  p_ovr_keeps_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && char_done && full_q && !clr_full) |=> (ovr_q && $stable(data_q)));

  // R3: receive-full falls only through an armed clear
  p_full_clear_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full_q) |-> $past(clr_full));

  // R5: overrun falls only through an armed clear
  p_ovr_clear_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr_q) |-> $past(clr_ovr));

  // R10: a disabled receiver does not take in characters
  p_disabled_no_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !clr_full) |=> $stable(data_q));

endmodule

// File: rtl/rxs_idle.sv
module rxs_idle (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic idle_det,
  input  logic load,
  input  logic clr_idle,
  output logic idle_o
);

  logic armed_q, armed_d;
  logic idle_q, idle_d;
  logic idle_set;

  // Arming comes from a loaded character. A clear or a disabled receiver drops it.
  always_comb begin
    armed_d  = rx_en & ((armed_q & ~clr_idle) | load);
    idle_set = idle_det & armed_q & rx_en & ~clr_idle;
    idle_d   = (idle_q & ~clr_idle) | idle_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      idle_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      idle_q  <= idle_d;
    end
  end

  assign idle_o = idle_q;

  // R7 / R8: idle can rise only when a character has armed it
  p_idle_needs_char_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_q) |-> $past(armed_q));

  // R10: disabling the receiver discards the arming
  p_disable_drops_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !armed_q);

  // R8: a clear of idle leaves no arming behind unless a character loads in that cycle
  p_clear_disarms_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_idle && !load) |=> !armed_q);

endmodule

// File: rtl/rx_status_ctrl.sv
module rx_status_ctrl
  import rxs_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int RST_SYNCS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              char_done,
  input  logic [DATA_W-1:0] char_data,
  input  logic              idle_det,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              ovr_ie,
  output logic              full_o,
  output logic              ovr_o,
  output logic              idle_o,
  output logic [DATA_W-1:0] data_o,
  output logic              err_irq_o
);

  logic       rst_int_n;
  rxs_flags_t flags;
  rxs_flags_t clr;
  logic       load;

  rxs_rst_sync #(.STAGES(RST_SYNCS)) i_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  rxs_clr_arm i_clr_arm (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .stat_rd (stat_rd),
    .data_rd (data_rd),
    .flags_i (flags),
    .clr_o   (clr)
  );

  rxs_hold #(.DATA_W(DATA_W)) i_hold (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rx_en     (rx_en),
    .char_done (char_done),
    .char_data (char_data),
    .clr_full  (clr.full),
    .clr_ovr   (clr.ovr),
    .full_o    (flags.full),
    .ovr_o     (flags.ovr),
    .load_o    (load),
    .data_o    (data_o)
  );

  rxs_idle i_idle (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rx_en    (rx_en),
    .idle_det (idle_det),
    .load     (load),
    .clr_idle (clr.idle),
    .idle_o   (flags.idle)
  );

  assign full_o    = flags.full;
  assign ovr_o     = flags.ovr;
  assign idle_o    = flags.idle;
  assign err_irq_o = flags.ovr & ovr_ie;

  // Input rule: a bus performs one access at a time
  p_rd_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(stat_rd && data_rd));

  // R1: while internal reset is held, every flag is low
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_int_n |=> (rst_int_n || (!full_o && !ovr_o && !idle_o)));

  // R9: a character during a clearing read keeps receive-full set with no overrun
  p_same_cycle_load_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (clr.full && rx_en && char_done && !ovr_o) |=> (full_o && !ovr_o));

endmodule

// File: tb/test_rx_status_ctrl.sv
module test_rx_status_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rx_en, char_done, idle_det, stat_rd, data_rd, ovr_ie;
  logic [DW-1:0] char_data;
  logic          full_o, ovr_o, idle_o, err_irq_o;
  logic [DW-1:0] data_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_status_ctrl #(.DATA_W(DW)) i_rx_status_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .char_done(char_done),
    .char_data(char_data), .idle_det(idle_det), .stat_rd(stat_rd),
    .data_rd(data_rd), .ovr_ie(ovr_ie), .full_o(full_o), .ovr_o(ovr_o),
    .idle_o(idle_o), .data_o(data_o), .err_irq_o(err_irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One cycle of strobes, driven at a falling edge and removed at the next one.
  task automatic step(input logic s, input logic d, input logic c,
                      input logic [DW-1:0] b, input logic i);
    @(negedge clk);
    stat_rd = s; data_rd = d; char_done = c; char_data = b; idle_det = i;
    @(negedge clk);
    stat_rd = 0; data_rd = 0; char_done = 0; idle_det = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; rx_en = 0; ovr_ie = 0;
    stat_rd = 0; data_rd = 0; char_done = 0; idle_det = 0; char_data = '0;
    repeat (2) @(negedge clk);
    chk("R1 full in reset", full_o, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    rx_en = 1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 full", full_o, 0);
    chk("R1 ovr", ovr_o, 0);
    chk("R1 idle", idle_o, 0);
    chk("R1 irq", err_irq_o, 0);
    chk("R1 data", data_o, 0);
  endtask

  task automatic t_load_clear();
    do_reset();
    step(0, 0, 1, 8'hA5, 0);
    chk("R2 full", full_o, 1);
    chk("R2 data", data_o, 8'hA5);
    step(0, 1, 0, 0, 0);
    chk("R3 unarmed data read", full_o, 1);
    step(1, 0, 0, 0, 0);
    chk("R3 status read only", full_o, 1);
    step(0, 1, 0, 0, 0);
    chk("R3 armed clear", full_o, 0);
    chk("R3 data kept", data_o, 8'hA5);
  endtask

  task automatic t_overrun_irq();
    do_reset();
    step(0, 0, 1, 8'h11, 0);
    step(0, 0, 1, 8'h22, 0);
    chk("R4 ovr", ovr_o, 1);
    chk("R4 data kept", data_o, 8'h11);
    chk("R6 irq masked", err_irq_o, 0);
    ovr_ie = 1; #1;
    chk("R6 irq enabled", err_irq_o, 1);
    ovr_ie = 0; #1;
    chk("R6 irq masked again", err_irq_o, 0);
  endtask

  task automatic t_delayed_clear();
    do_reset();
    step(0, 0, 1, 8'hB1, 0);
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 8'hB2, 0);
    chk("R4 ovr after late byte", ovr_o, 1);
    step(0, 1, 0, 0, 0);
    chk("R5 ovr survives unarmed read", ovr_o, 1);
    chk("R5 full cleared", full_o, 0);
    chk("R5 data is first byte", data_o, 8'hB1);
    step(0, 0, 1, 8'hB3, 0);
    chk("R2 reload", data_o, 8'hB3);
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    chk("R5 ovr armed clear", ovr_o, 0);
    chk("R3 full armed clear", full_o, 0);
  endtask

  task automatic t_consumed();
    do_reset();
    step(0, 0, 1, 8'hC1, 0);
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    step(0, 0, 1, 8'hC2, 0);
    step(0, 1, 0, 0, 0);
    chk("R11 second read clears nothing", full_o, 1);
    chk("R11 data", data_o, 8'hC2);
  endtask

  task automatic t_idle();
    do_reset();
    step(0, 0, 0, 0, 1);
    chk("R7 idle before char", idle_o, 0);
    step(0, 0, 1, 8'hD1, 0);
    step(0, 0, 0, 0, 1);
    chk("R7 idle after char", idle_o, 1);
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    chk("R8 idle cleared", idle_o, 0);
    step(0, 0, 0, 0, 1);
    chk("R8 idle not rearmed", idle_o, 0);
    step(0, 0, 1, 8'hD2, 0);
    step(0, 0, 0, 0, 1);
    chk("R8 idle rearmed", idle_o, 1);
  endtask

  task automatic t_same_cycle();
    do_reset();
    step(0, 0, 1, 8'h33, 0);
    step(1, 0, 0, 0, 0);
    step(0, 1, 1, 8'h44, 0);
    chk("R9 full", full_o, 1);
    chk("R9 no ovr", ovr_o, 0);
    chk("R9 data", data_o, 8'h44);
  endtask

  task automatic t_disable();
    do_reset();
    step(0, 0, 1, 8'h55, 0);
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    @(negedge clk); rx_en = 0;
    step(0, 0, 1, 8'h66, 0);
    chk("R10 no load when off", full_o, 0);
    chk("R10 data unchanged", data_o, 8'h55);
    @(negedge clk); rx_en = 1;
    step(0, 0, 0, 0, 1);
    chk("R10 arming dropped", idle_o, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_load_clear();
        t_overrun_irq();
        t_delayed_clear();
        t_consumed();
        t_idle();
        t_same_cycle();
        t_disable();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule